// File: doc/BRIEF.md
# Exception Entry and Reset Sequencer

This block walks a 32-bit memory port through the fixed bus sequences a processor needs at power-up and when it takes an exception. A reset request reads the starting stack pointer and program counter from the bottom of memory and yields the supervisor status word. An exception request carries a vector number, or an illegal opcode that is turned into one. The block then builds a short frame on the supervisor stack: the program counter as a long word, with the old status word below it. It then reads the handler address from the vector table. If that entry is empty, it falls back to the uninitialized-interrupt entry.

The surrounding core provides the current program counter, status word and stack pointer when it raises a request. When the done strobe pulses, the core loads the new program counter, stack pointer and status word. Every access waits for its acknowledge, so the block works with memory that inserts any number of wait states.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_ni is low and afterwards until a request arrives, busy_o, done_o and mem_req_o are 0.
- R2: A reset request reads a long from address 0 into new_sp_o, then a long from address 4 into new_pc_o. It sets new_sr_o to 0x2700: both trace bits (15, 14) clear, supervisor bit 13 set, interrupt mask bits 10:8 equal to 7, all other bits 0.
- R3: An exception sets new_sr_o to the captured status word with bits 15 and 14 cleared and bit 13 set. All other bits are kept.
- R4: The frame is pushed in a fixed order. First comes a long write of the captured program counter at SP-4. Then comes a word write of the captured, unmodified status word at SP-6. new_sp_o ends at SP-6.
- R5: The handler address placed on new_pc_o is the long read at vector*4.
- R6: If the long read at vector*4 is zero, the long at address 60 (vector 15) is read and becomes new_pc_o.
- R7: An illegal-opcode request maps opcode bits 15:12 to a vector: 0xF gives 11, 0xA gives 10, and every other value gives 4.
- R8: Port encoding is as follows. mem_size_o is 1 for a long and 0 for a word. Longs are big-endian, so the byte at the access address is bits 31:24. Word write data travels on mem_wdata_o[15:0].
- R9: Once raised, mem_req_o together with its address, write enable, size and write data holds steady until mem_ack_i is seen.
- R10: busy_o goes high the cycle after a request is accepted and stays high through the done cycle. Any request that arrives while busy_o is high is ignored.
- R11: done_o is a single-cycle pulse. In that cycle new_pc_o, new_sp_o and new_sr_o carry the final values.
- R12: When requests arrive in the same cycle, reset beats exception, and exception beats illegal opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Start the reset load sequence |
| exc_req_i | input | 1 | Start exception entry with exc_vec_i |
| exc_vec_i | input | 8 | Exception vector number |
| ill_req_i | input | 1 | Start exception entry for an illegal opcode |
| ill_opcode_i | input | 16 | Offending opcode |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 16 | Current status word |
| sp_i | input | 32 | Current supervisor stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_size_o | output | 1 | 1 = long, 0 = word |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data (word on bits 15:0) |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access complete |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| new_pc_o | output | 32 | Resulting program counter |
| new_sp_o | output | 32 | Resulting stack pointer |
| new_sr_o | output | 16 | Resulting status word |

## Verification
The bench reads back the stack frame from its memory model byte by byte. A design that swaps the push order, writes the modified status word instead of the old one, or puts the word on the wrong data lanes leaves the wrong bytes at SP-6..SP-1. An empty vector-table entry checks the fallback read, and a design without it would return zero as the handler. Requests raised during a running sequence, and requests raised together, check that a design does not restart or pick the wrong source, which would show up as a different handler address or a reset-style result. Wait states that vary per access check that the stack pointer moves only on an acknowledge; a design that commits early would end more than six bytes below the start.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_SP, ST_RD_PC, ST_WR_PC, ST_WR_SR, ST_RD_VEC, ST_RD_UNINIT, ST_DONE
  } seq_state_e;

  localparam int SR_T1      = 15;
  localparam int SR_T0      = 14;
  localparam int SR_SUP     = 13;
  localparam int SR_MASK_LO = 8;
  localparam int SR_MASK_W  = 3;

  localparam int VEC_ILLEGAL = 4;
  localparam int VEC_LINE_A  = 10;
  localparam int VEC_LINE_F  = 11;
  localparam int VEC_UNINIT  = 15;
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_seq_pkg::*;
#(
  parameter int VW  = 8,
  parameter int OPW = 16
) (
  input  logic           exc_req_i,
  input  logic [VW-1:0]  exc_vec_i,
  input  logic           ill_req_i,
  input  logic [OPW-1:0] ill_opcode_i,
  output logic           go_o,
  output logic [VW-1:0]  vec_o
);
  localparam int TOP = OPW - 4;

  logic [VW-1:0] ill_vec;

  always_comb begin
    unique case (ill_opcode_i[OPW-1:TOP])
      4'hF:    ill_vec = VW'(VEC_LINE_F);
      4'hA:    ill_vec = VW'(VEC_LINE_A);
      default: ill_vec = VW'(VEC_ILLEGAL);
    endcase
  end

  assign go_o  = exc_req_i | ill_req_i;
  assign vec_o = exc_req_i ? exc_vec_i : ill_vec;
endmodule

// File: rtl/exc_sr_gen.sv
module exc_sr_gen
  import exc_seq_pkg::*;
#(
  parameter int SRW        = 16,
  parameter int RESET_MASK = 7
) (
  input  logic [SRW-1:0] sr_i,
  output logic [SRW-1:0] exc_sr_o,
  output logic [SRW-1:0] rst_sr_o
);
  always_comb begin
    exc_sr_o         = sr_i;
    exc_sr_o[SR_T1]  = 1'b0;
    exc_sr_o[SR_T0]  = 1'b0;
    exc_sr_o[SR_SUP] = 1'b1;

    rst_sr_o         = '0;
    rst_sr_o[SR_SUP] = 1'b1;
    rst_sr_o[SR_MASK_LO +: SR_MASK_W] = SR_MASK_W'(RESET_MASK);
  end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_seq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int VW      = 8,
  parameter int SRW     = 16,
  parameter int SP_ADDR = 0,
  parameter int PC_ADDR = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rst_req_i,
  input  logic           exc_go_i,
  input  logic [VW-1:0]  vec_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [SRW-1:0] sr_i,
  input  logic [AW-1:0]  sp_i,
  input  logic [SRW-1:0] exc_sr_i,
  input  logic [SRW-1:0] rst_sr_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic           mem_size_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ack_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [AW-1:0]  new_pc_o,
  output logic [AW-1:0]  new_sp_o,
  output logic [SRW-1:0] new_sr_o
);
  localparam int          VPAD      = AW - VW - 2;
  localparam logic [AW-1:0] LONG_B  = AW'(4);
  localparam logic [AW-1:0] WORD_B  = AW'(2);
  localparam logic [AW-1:0] UNINIT_A = AW'(VEC_UNINIT * 4);

  seq_state_e     state_q, state_d;
  logic [AW-1:0]  pc_q, sp_q;
  logic [SRW-1:0] sr_q, old_sr_q;
  logic [VW-1:0]  vec_q;
  logic           acc;

  assign acc = mem_req_o & mem_ack_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_size_o  = 1'b1;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    state_d     = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rst_req_i)     state_d = ST_RD_SP;
        else if (exc_go_i) state_d = ST_WR_PC;
      end
      ST_RD_SP: begin
        mem_req_o  = 1'b1;
        mem_addr_o = AW'(SP_ADDR);
        if (mem_ack_i) state_d = ST_RD_PC;
      end
      ST_RD_PC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = AW'(PC_ADDR);
        if (mem_ack_i) state_d = ST_DONE;
      end
      ST_WR_PC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - LONG_B;
        mem_wdata_o = DW'(pc_q);
        if (mem_ack_i) state_d = ST_WR_SR;
      end
      ST_WR_SR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_size_o  = 1'b0;
        mem_addr_o  = sp_q - WORD_B;
        mem_wdata_o = DW'(old_sr_q);
        if (mem_ack_i) state_d = ST_RD_VEC;
      end
      ST_RD_VEC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {{VPAD{1'b0}}, vec_q, 2'b00};
        if (mem_ack_i) state_d = (mem_rdata_i == '0) ? ST_RD_UNINIT : ST_DONE;
      end
      ST_RD_UNINIT: begin
        mem_req_o  = 1'b1;
        mem_addr_o = UNINIT_A;
        if (mem_ack_i) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      sp_q     <= '0;
      sr_q     <= '0;
      old_sr_q <= '0;
      vec_q    <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: begin
          if (rst_req_i) begin
            sr_q <= rst_sr_i;
          end else if (exc_go_i) begin
            pc_q     <= pc_i;
            sp_q     <= sp_i;
            old_sr_q <= sr_i;
            sr_q     <= exc_sr_i;
            vec_q    <= vec_i;
          end
        end
        ST_RD_SP:     if (acc) sp_q <= AW'(mem_rdata_i);
        ST_RD_PC:     if (acc) pc_q <= AW'(mem_rdata_i);
        ST_WR_PC:     if (acc) sp_q <= sp_q - LONG_B;
        ST_WR_SR:     if (acc) sp_q <= sp_q - WORD_B;
        ST_RD_VEC:    if (acc && mem_rdata_i != '0) pc_q <= AW'(mem_rdata_i);
        ST_RD_UNINIT: if (acc) pc_q <= AW'(mem_rdata_i);
        default: ;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign new_pc_o = pc_q;
  assign new_sp_o = sp_q;
  assign new_sr_o = sr_q;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int VW         = 8,
  parameter int OPW        = 16,
  parameter int SRW        = 16,
  parameter int RESET_MASK = 7,
  parameter int SP_ADDR    = 0,
  parameter int PC_ADDR    = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rst_req_i,
  input  logic           exc_req_i,
  input  logic [VW-1:0]  exc_vec_i,
  input  logic           ill_req_i,
  input  logic [OPW-1:0] ill_opcode_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [SRW-1:0] sr_i,
  input  logic [AW-1:0]  sp_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic           mem_size_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ack_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [AW-1:0]  new_pc_o,
  output logic [AW-1:0]  new_sp_o,
  output logic [SRW-1:0] new_sr_o
);
  logic           exc_go;
  logic [VW-1:0]  vec;
  logic [SRW-1:0] exc_sr, rst_sr;

  exc_vec_sel #(.VW(VW), .OPW(OPW)) u_vec (
    .exc_req_i    (exc_req_i),
    .exc_vec_i    (exc_vec_i),
    .ill_req_i    (ill_req_i),
    .ill_opcode_i (ill_opcode_i),
    .go_o         (exc_go),
    .vec_o        (vec)
  );

  exc_sr_gen #(.SRW(SRW), .RESET_MASK(RESET_MASK)) u_sr (
    .sr_i     (sr_i),
    .exc_sr_o (exc_sr),
    .rst_sr_o (rst_sr)
  );

  exc_seq_fsm #(
    .AW(AW), .DW(DW), .VW(VW), .SRW(SRW), .SP_ADDR(SP_ADDR), .PC_ADDR(PC_ADDR)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_req_i   (rst_req_i),
    .exc_go_i    (exc_go),
    .vec_i       (vec),
    .pc_i        (pc_i),
    .sr_i        (sr_i),
    .sp_i        (sp_i),
    .exc_sr_i    (exc_sr),
    .rst_sr_i    (rst_sr),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_size_o  (mem_size_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .new_pc_o    (new_pc_o),
    .new_sp_o    (new_sp_o),
    .new_sr_o    (new_sr_o)
  );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SRW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic           mem_size_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic [DW-1:0]  mem_wdata_o,
  input logic           mem_ack_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [SRW-1:0] new_sr_o
);
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_size_o) && $stable(mem_wdata_o)));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o));

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  assert_super_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (new_sr_o[13] && !new_sr_o[15] && !new_sr_o[14]));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW), .DW(DW), .SRW(SRW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_size_o  (mem_size_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .new_sr_o    (new_sr_o)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_req_i = 1'b0, exc_req_i = 1'b0, ill_req_i = 1'b0;
  logic [7:0]  exc_vec_i = '0;
  logic [15:0] ill_opcode_i = '0;
  logic [31:0] pc_i = '0, sp_i = '0;
  logic [15:0] sr_i = '0;
  logic        mem_req_o, mem_we_o, mem_size_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        busy_o, done_o;
  logic [31:0] new_pc_o, new_sp_o;
  logic [15:0] new_sr_o;

  int checks = 0, errors = 0, cycles = 0;
  int wait_cfg = 0, wcnt = 0;
  logic [7:0]  stk [1024];
  logic        log_clr = 1'b0;
  int          wr_cnt = 0;
  logic [31:0] wr0_addr = '0;
  logic        wr0_size = 1'b0;

  always #4 clk_i = ~clk_i;

  exc_entry_seq dut_i (.*);

  function automatic logic [31:0] vt(input int n);
    if (n == 0) return 32'h0000_0380;
    if (n == 1) return 32'h0000_0200;
    if (n == 30) return 32'h0;
    if (n == 15) return 32'h0000_BEE0;
    return 32'h0001_0000 + 32'(n) * 32'h100;
  endfunction

  function automatic logic [31:0] rd_long(input logic [31:0] a);
    if (a < 32'd256) return vt(int'(a >> 2));
    return {stk[a[9:0]], stk[a[9:0]+10'd1], stk[a[9:0]+10'd2], stk[a[9:0]+10'd3]};
  endfunction

  assign mem_ack_i   = mem_req_o && (wcnt == wait_cfg);
  assign mem_rdata_i = rd_long(mem_addr_o);

  always @(posedge clk_i) begin
    if (!mem_req_o || mem_ack_i) wcnt <= 0; else wcnt <= wcnt + 1;
    if (log_clr) wr_cnt <= 0;
    if (mem_req_o && mem_ack_i && mem_we_o) begin
      if (wr_cnt == 0) begin wr0_addr <= mem_addr_o; wr0_size <= mem_size_o; end
      wr_cnt <= wr_cnt + 1;
      if (mem_size_o) begin
        stk[mem_addr_o[9:0]]       <= mem_wdata_o[31:24];
        stk[mem_addr_o[9:0]+10'd1] <= mem_wdata_o[23:16];
        stk[mem_addr_o[9:0]+10'd2] <= mem_wdata_o[15:8];
        stk[mem_addr_o[9:0]+10'd3] <= mem_wdata_o[7:0];
      end else begin
        stk[mem_addr_o[9:0]]       <= mem_wdata_o[15:8];
        stk[mem_addr_o[9:0]+10'd1] <= mem_wdata_o[7:0];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (done_o) begin seen = 1'b1; break; end
    end
  endtask

  // kind: 0 exception, 1 illegal opcode
  localparam int N = 6;
  localparam logic        T_ILL  [N] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [15:0] T_CODE [N] = '{16'd5, 16'd30, 16'hF123, 16'hA000, 16'h4AFC, 16'd63};
  localparam logic [31:0] T_PC   [N] = '{32'h0000_1234, 32'hABCD_0002, 32'h0000_0800,
                                         32'h0000_0902, 32'h0000_FFFE, 32'h1234_5678};
  localparam logic [15:0] T_SR   [N] = '{16'hC31F, 16'h0004, 16'h8700, 16'h4000, 16'h2010, 16'hFFFF};
  localparam logic [31:0] T_SP   [N] = '{32'h300, 32'h3F0, 32'h200, 32'h280, 32'h3C0, 32'h380};
  localparam logic [31:0] E_PC   [N] = '{32'h1_0500, 32'h0000_BEE0, 32'h1_0B00,
                                         32'h1_0A00, 32'h1_0400, 32'h1_3F00};
  localparam logic [31:0] E_SP   [N] = '{32'h2FA, 32'h3EA, 32'h1FA, 32'h27A, 32'h3BA, 32'h37A};
  localparam logic [15:0] E_SR   [N] = '{16'h231F, 16'h2004, 16'h2700, 16'h2000, 16'h2010, 16'h3FFF};

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog act=%0d exp=<20000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit seen;
    logic [31:0] fsp;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o, "R1 idle in reset", {29'b0, busy_o, done_o, mem_req_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o, "R1 idle after reset", {29'b0, busy_o, done_o, mem_req_o}, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R8 R11 with varying wait states (R9)
    for (int i = 0; i < N; i++) begin
      wait_cfg = i % 3;
      log_clr = 1'b1;
      exc_req_i = !T_ILL[i]; ill_req_i = T_ILL[i];
      exc_vec_i = T_CODE[i][7:0]; ill_opcode_i = T_CODE[i];
      pc_i = T_PC[i]; sr_i = T_SR[i]; sp_i = T_SP[i];
      @(negedge clk_i);
      log_clr = 1'b0; exc_req_i = 1'b0; ill_req_i = 1'b0;
      chk(busy_o, "R10 busy after accept", {31'b0, busy_o}, 32'h1);
      wait_done(seen);
      chk(seen, "R11 done seen", {31'b0, seen}, 32'h1);
      chk(new_pc_o == E_PC[i], $sformatf("R5 R6 R7 row %0d pc", i), new_pc_o, E_PC[i]);
      chk(new_sp_o == E_SP[i], $sformatf("R4 row %0d sp", i), new_sp_o, E_SP[i]);
      chk(new_sr_o == E_SR[i], $sformatf("R3 row %0d sr", i), {16'b0, new_sr_o}, {16'b0, E_SR[i]});
      fsp = E_SP[i];
      chk({stk[fsp[9:0]], stk[fsp[9:0]+10'd1]} == T_SR[i], "R4 R8 frame sr",
          {16'b0, stk[fsp[9:0]], stk[fsp[9:0]+10'd1]}, {16'b0, T_SR[i]});
      chk(rd_long(fsp + 32'd2) == T_PC[i], "R4 R8 frame pc", rd_long(fsp + 32'd2), T_PC[i]);
      chk(stk[fsp[9:0]+10'd2] == T_PC[i][31:24], "R8 big-endian msb", {24'b0, stk[fsp[9:0]+10'd2]},
          {24'b0, T_PC[i][31:24]});
      chk(wr0_addr == T_SP[i] - 32'd4 && wr0_size && wr_cnt == 2, "R4 first write long at SP-4",
          wr0_addr, T_SP[i] - 32'd4);
      @(negedge clk_i);
      chk(!done_o && !busy_o, "R11 single pulse", {30'b0, done_o, busy_o}, 32'h0);
    end

    // reset sequence R2
    wait_cfg = 1;
    rst_req_i = 1'b1;
    @(negedge clk_i);
    rst_req_i = 1'b0;
    wait_done(seen);
    chk(new_sp_o == 32'h380, "R2 reset sp", new_sp_o, 32'h380);
    chk(new_pc_o == 32'h200, "R2 reset pc", new_pc_o, 32'h200);
    chk(new_sr_o == 16'h2700, "R2 reset sr", {16'b0, new_sr_o}, 32'h2700);
    @(negedge clk_i);

    // priority R12: reset wins over exception
    sr_i = 16'hC000; sp_i = 32'h300; pc_i = 32'h44;
    rst_req_i = 1'b1; exc_req_i = 1'b1; exc_vec_i = 8'd5;
    @(negedge clk_i);
    rst_req_i = 1'b0; exc_req_i = 1'b0;
    wait_done(seen);
    chk(new_pc_o == 32'h200 && new_sr_o == 16'h2700, "R12 reset beats exception", new_pc_o, 32'h200);
    @(negedge clk_i);

    // priority R12: exception vector beats illegal opcode
    exc_req_i = 1'b1; exc_vec_i = 8'd5; ill_req_i = 1'b1; ill_opcode_i = 16'hF000;
    @(negedge clk_i);
    exc_req_i = 1'b0; ill_req_i = 1'b0;
    wait_done(seen);
    chk(new_pc_o == 32'h1_0500, "R12 exception beats illegal", new_pc_o, 32'h1_0500);
    @(negedge clk_i);

    // R10: requests during busy ignored
    wait_cfg = 2;
    exc_req_i = 1'b1; exc_vec_i = 8'd6; sp_i = 32'h300; sr_i = 16'h0000;
    @(negedge clk_i);
    exc_vec_i = 8'd7; rst_req_i = 1'b1; sp_i = 32'h3F0;
    repeat (3) @(negedge clk_i);
    exc_req_i = 1'b0; rst_req_i = 1'b0;
    wait_done(seen);
    chk(new_pc_o == 32'h1_0600, "R10 busy ignores pc", new_pc_o, 32'h1_0600);
    chk(new_sp_o == 32'h2FA, "R10 busy ignores sp", new_sp_o, 32'h2FA);
    @(negedge clk_i);
    chk(!busy_o, "R10 idle after done", {31'b0, busy_o}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule